// File: doc/BRIEF.md
# Frame Memory Rectangle Mover

This block copies a rectangular window of 16-bit pixels between a 32-bit streaming data port and a 1024 by 512 pixel frame memory. A single start strobe supplies a packed position word, a packed size word and a direction bit. In write mode the block takes data words from the stream and writes their pixels into memory. In read mode it fetches pixels from memory and offers them as data words. The first word is fetched on its own as soon as the read starts.

Every data word holds two pixels. The block keeps a cursor made of the current row, the column inside that row and the number of rows still to go. Because of this cursor the stream can stall between any two words, including in the middle of a row, and the transfer continues at the exact pixel where it stopped. When the last row is finished the block returns to idle, ready for the next command, and raises a one-cycle completion pulse. The memory side is a plain synchronous single-port RAM with 16-bit words and one cycle of read latency.

Top module: `vrm_rect_mover`

## Requirements
- R1: The start command is decoded as follows. Column X is start_pos_i[9:0] and row Y is start_pos_i[24:16]. The width in pixels is start_size_i[15:0] and the height in rows is start_size_i[31:16]. Bits [15:10] and [31:25] of the position word have no effect.
- R2: The memory address of a pixel is row*1024 + column, with row = (Y + rows done) mod 512 and column = (X + col) mod 1024. Both coordinates therefore wrap.
- R3: In write mode each accepted word causes two memory writes. The pixel in bits [15:0] is written first, in the cycle after acceptance, and the pixel in bits [31:16] is written in the cycle after that. Pixels fill the rectangle row by row, left to right.
- R4: After `width` pixels of a row have been moved, the column returns to 0, the row advances by one and the remaining height drops by one.
- R5: The transfer may pause between any two words, with wr_valid_i low or rd_ready_i low, even in the middle of a row. It resumes at the next pixel of that row, so no pixel is lost or repeated.
- R6: In read mode the pixel at the lower position goes to bits [15:0] and the next pixel to bits [31:16]. The first word becomes valid 4 cycles after the start cycle without any request from the consumer. While rd_valid_o is high and rd_ready_i is low, rd_valid_o and rd_data_o hold their values.
- R7: When width*height is odd, the upper half of the final word is dropped. A write does not store it, and a read returns it as 0.
- R8: done_o pulses for one cycle. A write raises it in the cycle after the final pixel write, and a read raises it in the cycle after the final word is accepted. busy_o is low in that cycle.
- R9: A start with zero width or zero height makes no memory access and raises done_o in the next cycle.
- R10: A start while busy_o is high is ignored, and the running transfer continues unchanged. err_o is high in the next cycle.
- R11: While reset is held, busy_o, done_o, err_o, mem_en_o, wr_ready_o and rd_valid_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe for a transfer |
| start_read_i | input | 1 | Direction: 1 reads memory to the stream, 0 writes the stream to memory |
| start_pos_i | input | 32 | Packed start position |
| start_size_i | input | 32 | Packed width and height |
| wr_valid_i | input | 1 | A write-mode data word is present |
| wr_data_i | input | 32 | Write-mode data word, two pixels |
| wr_ready_o | output | 1 | The block takes wr_data_i at this edge |
| rd_valid_o | output | 1 | A read-mode data word is present |
| rd_data_o | output | 32 | Read-mode data word, two pixels |
| rd_ready_i | input | 1 | The consumer takes rd_data_o at this edge |
| mem_en_o | output | 1 | Memory access enable |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 19 | Memory pixel address |
| mem_wdata_o | output | 16 | Pixel written to memory |
| mem_rdata_i | input | 16 | Pixel read from memory, one cycle after the access |
| busy_o | output | 1 | A transfer is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle flag for a start rejected while busy |

## Verification
Each result has a fixed latency, and the bench samples at exactly that cycle.
- A write word accepted at an edge produces its low pixel write in the next cycle and its high pixel write in the cycle after that.
- A read start has its first word valid 4 cycles after the start cycle.
- done_o comes exactly one cycle after the last pixel write or the last word handshake.
- err_o comes one cycle after a start issued while busy.

The bench drives inputs on the falling edge and samples one time unit later, so each value it sees is the one the next rising edge acts on. A monitor compares every memory write and every read handshake, in order, against queues that the drivers fill from the requirements. The monitor records the cycle of the final event, and the drivers check done_o against that cycle plus one.

// File: rtl/vrm_pkg.sv
package vrm_pkg;
    localparam int X_W    = 10;
    localparam int Y_W    = 9;
    localparam int DIM_W  = 16;
    localparam int PIX_W  = 16;
    localparam int WORD_W = 2 * PIX_W;
    localparam int ADDR_W = X_W + Y_W;
    localparam int Y_LSB  = 16;

    typedef struct packed {
        logic [X_W-1:0]   x;
        logic [Y_W-1:0]   y;
        logic [DIM_W-1:0] w;
        logic [DIM_W-1:0] h;
    } rect_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_W_ACC,
        ST_W_LO,
        ST_W_HI,
        ST_R_LO,
        ST_R_HI,
        ST_R_CAP,
        ST_R_OUT
    } xfer_state_e;

    function automatic rect_t unpack_rect(input logic [WORD_W-1:0] pos,
                                          input logic [WORD_W-1:0] size);
        rect_t r;
        r.x = pos[X_W-1:0];
        r.y = pos[Y_LSB +: Y_W];
        r.w = size[DIM_W-1:0];
        r.h = size[WORD_W-1:DIM_W];
        return r;
    endfunction

    function automatic logic rect_empty(input rect_t r);
        return (r.w == '0) || (r.h == '0);
    endfunction

    function automatic logic [ADDR_W-1:0] pix_addr(input logic [Y_W-1:0] y,
                                                   input logic [X_W-1:0] x,
                                                   input logic [X_W-1:0] col);
        logic [X_W-1:0] xs;
        xs = x + col;
        return {y, xs};
    endfunction
endpackage

// File: rtl/vrm_cursor.sv
module vrm_cursor
    import vrm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  rect_t             rect_i,
    input  logic              step,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o
);
    localparam logic [DIM_W:0]   ONE_EXT = (DIM_W+1)'(1);
    localparam logic [DIM_W-1:0] ONE_DIM = DIM_W'(1);

    logic [X_W-1:0]   x_q;
    logic [Y_W-1:0]   y_q;
    logic [DIM_W-1:0] w_q;
    logic [DIM_W-1:0] h_q;
    logic [DIM_W-1:0] col_q;
    logic [DIM_W:0]   col_inc;
    logic             row_end;

    assign col_inc = {1'b0, col_q} + ONE_EXT;
    assign row_end = (col_inc == {1'b0, w_q});
    assign last_o  = row_end && (h_q == ONE_DIM);
    assign addr_o  = pix_addr(y_q, x_q, col_q[X_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q   <= '0;
            y_q   <= '0;
            w_q   <= '0;
            h_q   <= '0;
            col_q <= '0;
        end else if (load) begin
            x_q   <= rect_i.x;
            y_q   <= rect_i.y;
            w_q   <= rect_i.w;
            h_q   <= rect_i.h;
            col_q <= '0;
        end else if (step) begin
            if (row_end) begin
                col_q <= '0;
                y_q   <= y_q + 1'b1;
                h_q   <= h_q - ONE_DIM;
            end else begin
                col_q <= col_inc[DIM_W-1:0];
            end
        end
    end

    // R8: the final pixel step drains the remaining height to zero
    assert_h_drains_R8: assert property (@(posedge clk) disable iff (rst)
        step && last_o |=> h_q == '0);

    // R9: no pixel step is taken with nothing left to move
    assert_no_empty_step_R9: assert property (@(posedge clk) disable iff (rst)
        step |-> h_q != '0);

    // R4: a row end returns the column to zero on the next cycle
    assert_row_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        step && row_end && !last_o |=> col_q == '0);
endmodule

// File: rtl/vrm_ctrl.sv
module vrm_ctrl
    import vrm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              start_read_i,
    input  logic              empty_i,
    input  logic              last_i,
    input  logic              wr_valid_i,
    input  logic [WORD_W-1:0] wr_data_i,
    output logic              wr_ready_o,
    output logic              rd_valid_o,
    output logic [WORD_W-1:0] rd_data_o,
    input  logic              rd_ready_i,
    input  logic [PIX_W-1:0]  mem_rdata_i,
    output logic              load_o,
    output logic              step_o,
    output logic              mem_en_o,
    output logic              mem_we_o,
    output logic [PIX_W-1:0]  mem_wdata_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o
);
    xfer_state_e       state_q;
    logic [WORD_W-1:0] word_q;
    logic              fin_q;
    logic              done_q;
    logic              err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            word_q  <= '0;
            fin_q   <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= start_i && (state_q != ST_IDLE);
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    fin_q <= 1'b0;
                    if (empty_i)           done_q  <= 1'b1;
                    else if (start_read_i) state_q <= ST_R_LO;
                    else                   state_q <= ST_W_ACC;
                end
                ST_W_ACC: if (wr_valid_i) begin
                    word_q  <= wr_data_i;
                    state_q <= ST_W_LO;
                end
                ST_W_LO: begin
                    if (last_i) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        state_q <= ST_W_HI;
                    end
                end
                ST_W_HI: begin
                    if (last_i) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        state_q <= ST_W_ACC;
                    end
                end
                ST_R_LO: begin
                    fin_q   <= last_i;
                    state_q <= ST_R_HI;
                end
                ST_R_HI: begin
                    word_q[PIX_W-1:0] <= mem_rdata_i;
                    if (fin_q) begin
                        word_q[WORD_W-1:PIX_W] <= '0;
                        state_q <= ST_R_OUT;
                    end else begin
                        fin_q   <= last_i;
                        state_q <= ST_R_CAP;
                    end
                end
                ST_R_CAP: begin
                    word_q[WORD_W-1:PIX_W] <= mem_rdata_i;
                    state_q <= ST_R_OUT;
                end
                ST_R_OUT: if (rd_ready_i) begin
                    if (fin_q) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        state_q <= ST_R_LO;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        load_o      = (state_q == ST_IDLE) && start_i && !empty_i;
        mem_we_o    = (state_q == ST_W_LO) || (state_q == ST_W_HI);
        mem_en_o    = mem_we_o || (state_q == ST_R_LO) ||
                      ((state_q == ST_R_HI) && !fin_q);
        step_o      = mem_en_o;
        mem_wdata_o = (state_q == ST_W_HI) ? word_q[WORD_W-1:PIX_W]
                                           : word_q[PIX_W-1:0];
        wr_ready_o  = (state_q == ST_W_ACC);
        rd_valid_o  = (state_q == ST_R_OUT);
        rd_data_o   = word_q;
        busy_o      = (state_q != ST_IDLE);
        done_o      = done_q;
        err_o       = err_q;
    end

    // R3: an accepted word is followed at once by a memory write
    assert_word_writes_R3: assert property (@(posedge clk) disable iff (rst)
        wr_ready_o && wr_valid_i |=> mem_en_o && mem_we_o);

    // R6: an offered read word is held until taken
    assert_rd_hold_R6: assert property (@(posedge clk) disable iff (rst)
        rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_data_o));

    // R8: completion is only flagged once the block is idle
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R10: a start while busy raises the error flag on the next cycle
    assert_err_on_busy_R10: assert property (@(posedge clk) disable iff (rst)
        start_i && busy_o |=> err_o);
endmodule

// File: rtl/vrm_rect_mover.sv
module vrm_rect_mover
    import vrm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              start_read_i,
    input  logic [WORD_W-1:0] start_pos_i,
    input  logic [WORD_W-1:0] start_size_i,
    input  logic              wr_valid_i,
    input  logic [WORD_W-1:0] wr_data_i,
    output logic              wr_ready_o,
    output logic              rd_valid_o,
    output logic [WORD_W-1:0] rd_data_o,
    input  logic              rd_ready_i,
    output logic              mem_en_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [PIX_W-1:0]  mem_wdata_o,
    input  logic [PIX_W-1:0]  mem_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o
);
    rect_t rect_in;
    logic  load;
    logic  step;
    logic  last;
    logic  unused_pos_bits;

    assign rect_in         = unpack_rect(start_pos_i, start_size_i);
    assign unused_pos_bits = ^{start_pos_i[WORD_W-1:Y_LSB+Y_W], start_pos_i[Y_LSB-1:X_W]};

    vrm_cursor u_cursor (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .rect_i (rect_in),
        .step   (step),
        .addr_o (mem_addr_o),
        .last_o (last)
    );

    vrm_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .start_read_i (start_read_i),
        .empty_i      (rect_empty(rect_in)),
        .last_i       (last),
        .wr_valid_i   (wr_valid_i),
        .wr_data_i    (wr_data_i),
        .wr_ready_o   (wr_ready_o),
        .rd_valid_o   (rd_valid_o),
        .rd_data_o    (rd_data_o),
        .rd_ready_i   (rd_ready_i),
        .mem_rdata_i  (mem_rdata_i),
        .load_o       (load),
        .step_o       (step),
        .mem_en_o     (mem_en_o),
        .mem_we_o     (mem_we_o),
        .mem_wdata_o  (mem_wdata_o),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .err_o        (err_o)
    );
endmodule

// File: tb/vrm_rect_mover_tb.sv
module vrm_rect_mover_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, start_read = 1'b0;
    logic [31:0] pos = '0, size = '0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_ready, rd_valid, rd_ready = 1'b0;
    logic [31:0] rd_data;
    logic        mem_en, mem_we;
    logic [18:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata = '0;
    logic        busy, done, err;

    always #4 clk = ~clk;

    vrm_rect_mover u_dut (
        .clk(clk), .rst(rst), .start_i(start), .start_read_i(start_read),
        .start_pos_i(pos), .start_size_i(size),
        .wr_valid_i(wr_valid), .wr_data_i(wr_data), .wr_ready_o(wr_ready),
        .rd_valid_o(rd_valid), .rd_data_o(rd_data), .rd_ready_i(rd_ready),
        .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .busy_o(busy), .done_o(done), .err_o(err)
    );

    int checks = 0, fails = 0, cyc = 0, last_evt_cyc = 0, acc_cnt = 0;
    logic [15:0] mem_model [int];
    logic [15:0] shadow [int];
    int          exp_wr_a [$];
    logic [15:0] exp_wr_d [$];
    logic [31:0] exp_rd [$];
    bit          prev_stall = 1'b0;
    logic [31:0] prev_data = '0;

    function automatic logic [15:0] dflt(int a);
        return 16'(a) ^ 16'h5A3C;
    endfunction

    function automatic logic [15:0] pix(int a);
        return shadow.exists(a) ? shadow[a] : dflt(a);
    endfunction

    function automatic int exp_addr(int x0, int y0, int row, int col);
        return ((y0 + row) % 512) * 1024 + ((x0 + col) % 1024);
    endfunction

    function automatic logic [31:0] gen_word(int seed, int i);
        return {16'(seed * 7 + i * 2 + 1) ^ 16'h1111, 16'(seed * 7 + i * 2)};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) cyc++;

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem_model[int'(mem_addr)] = mem_wdata;
            else mem_rdata <= mem_model.exists(int'(mem_addr)) ?
                              mem_model[int'(mem_addr)] : dflt(int'(mem_addr));
        end
    end

    // Scoreboard monitor, sampled just after the falling edge
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            if (mem_en) acc_cnt++;
            if (mem_en && mem_we) begin
                last_evt_cyc = cyc;
                if (exp_wr_a.size() == 0) begin
                    check(1'b0, "R7", "unexpected pixel write", 32'(mem_addr), 32'h0);
                end else begin
                    int          ea;
                    logic [15:0] ed;
                    ea = exp_wr_a.pop_front();
                    ed = exp_wr_d.pop_front();
                    check(int'(mem_addr) == ea, "R2", "write address", 32'(mem_addr), 32'(ea));
                    check(mem_wdata == ed, "R3", "write pixel", 32'(mem_wdata), 32'(ed));
                end
            end
            if (rd_valid && rd_ready) begin
                last_evt_cyc = cyc;
                if (exp_rd.size() == 0) begin
                    check(1'b0, "R6", "unexpected read word", rd_data, 32'h0);
                end else begin
                    logic [31:0] ew;
                    ew = exp_rd.pop_front();
                    check(rd_data == ew, "R6", "read word", rd_data, ew);
                end
            end
            if (prev_stall)
                check(rd_valid && rd_data == prev_data, "R6", "held read word",
                      rd_data, prev_data);
            prev_stall = rd_valid && !rd_ready;
            prev_data  = rd_data;
        end
    end

    task automatic pulse_start(input logic [31:0] p, input logic [31:0] s, input logic rd);
        @(negedge clk);
        start = 1'b1; pos = p; size = s; start_read = rd;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        while (!done) @(negedge clk);
        check(cyc == last_evt_cyc + 1, req, "done one cycle after final event",
              32'(cyc), 32'(last_evt_cyc + 1));
        check(!busy, req, "idle with done", 32'(busy), 32'h0);
    endtask

    task automatic run_write(input logic [31:0] p, input logic [31:0] s,
                             input int seed, input int gap, input bit inject);
        int x0 = int'(p[9:0]);
        int y0 = int'(p[24:16]);
        int w  = int'(s[15:0]);
        int h  = int'(s[31:16]);
        int total = w * h;
        int nw = (total + 1) / 2;
        for (int i = 0; i < nw; i++) begin
            logic [31:0] wd = gen_word(seed, i);
            for (int k = 0; k < 2; k++) begin
                int pidx = 2 * i + k;
                if (pidx < total) begin
                    int a = exp_addr(x0, y0, pidx / w, pidx % w);
                    logic [15:0] d = (k == 1) ? wd[31:16] : wd[15:0];
                    exp_wr_a.push_back(a);
                    exp_wr_d.push_back(d);
                    shadow[a] = d;
                end
            end
        end
        pulse_start(p, s, 1'b0);
        for (int i = 0; i < nw; i++) begin
            repeat (gap) @(negedge clk);
            wr_valid = 1'b1;
            wr_data  = gen_word(seed, i);
            while (!wr_ready) @(negedge clk);
            @(negedge clk);
            wr_valid = 1'b0;
            if (inject && i == 0) begin
                // R10: start during a running transfer must be ignored
                start = 1'b1; pos = 32'h0005_0005; size = 32'h0002_0002; start_read = 1'b1;
                @(negedge clk);
                start = 1'b0;
                check(err == 1'b1, "R10", "error flag after busy start", 32'(err), 32'h1);
            end
        end
        wait_done("R8");
        check(exp_wr_a.size() == 0, "R3", "all pixels written",
              32'(exp_wr_a.size()), 32'h0);
    endtask

    task automatic run_read(input logic [31:0] p, input logic [31:0] s, input int stall);
        int x0 = int'(p[9:0]);
        int y0 = int'(p[24:16]);
        int w  = int'(s[15:0]);
        int h  = int'(s[31:16]);
        int total = w * h;
        int nw = (total + 1) / 2;
        for (int i = 0; i < nw; i++) begin
            logic [15:0] lo, hi;
            lo = pix(exp_addr(x0, y0, (2 * i) / w, (2 * i) % w));
            hi = (2 * i + 1 < total) ?
                 pix(exp_addr(x0, y0, (2 * i + 1) / w, (2 * i + 1) % w)) : 16'h0;
            exp_rd.push_back({hi, lo});
        end
        rd_ready = 1'b0;
        pulse_start(p, s, 1'b1);
        repeat (2) @(negedge clk);
        check(rd_valid == 1'b0, "R6", "no word before fetch completes", 32'(rd_valid), 32'h0);
        @(negedge clk);
        check(rd_valid == 1'b1, "R6", "first word fetched without request", 32'(rd_valid), 32'h1);
        for (int i = 0; i < nw; i++) begin
            repeat (stall) @(negedge clk);
            rd_ready = 1'b1;
            while (!rd_valid) @(negedge clk);
            @(negedge clk);
            rd_ready = 1'b0;
        end
        wait_done("R8");
        check(exp_rd.size() == 0, "R6", "all words read", 32'(exp_rd.size()), 32'h0);
    endtask

    task automatic run_zero(input logic [31:0] s);
        int a0;
        a0 = acc_cnt;
        @(negedge clk);
        start = 1'b1; pos = 32'h0001_0001; size = s; start_read = 1'b0;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b1, "R9", "done after empty start", 32'(done), 32'h1);
        check(busy == 1'b0, "R9", "stays idle", 32'(busy), 32'h0);
        repeat (3) @(negedge clk);
        check(acc_cnt == a0, "R9", "no memory access", 32'(acc_cnt - a0), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check({busy, done, err, mem_en, wr_ready, rd_valid} == 6'b0, "R11",
              "outputs low in reset", 32'({busy, done, err, mem_en, wr_ready, rd_valid}), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        // R1, R2, R3, R4: junk position bits, two full rows
        run_write(32'hFE00_FC00 | (32'd20 << 16) | 32'd10, {16'd2, 16'd4}, 1, 0, 1'b0);
        // R2, R5, R7: wrap both coordinates, odd count, gaps between words
        run_write((32'd511 << 16) | 32'd1022, {16'd3, 16'd3}, 2, 2, 1'b0);
        // R4, R5: a word that crosses a row boundary, with gaps
        run_write((32'd100 << 16) | 32'd200, {16'd2, 16'd5}, 3, 3, 1'b0);
        // R10: start while busy
        run_write((32'd300 << 16) | 32'd40, {16'd1, 16'd6}, 4, 0, 1'b1);
        check(!err, "R10", "error flag is a single pulse", 32'(err), 32'h0);
        // R6: read back with stalls
        run_read(32'hFE00_FC00 | (32'd20 << 16) | 32'd10, {16'd2, 16'd4}, 2);
        // R7, R2: odd count across the wrap, upper half zero
        run_read((32'd511 << 16) | 32'd1022, {16'd3, 16'd3}, 0);
        // R5: resume mid-row on read
        run_read((32'd100 << 16) | 32'd200, {16'd2, 16'd5}, 3);
        // R6: unwritten area
        run_read((32'd7 << 16) | 32'd9, {16'd1, 16'd2}, 0);
        // R9: zero height, zero width
        run_zero({16'd0, 16'd4});
        run_zero({16'd3, 16'd0});
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule